// File: doc/BRIEF.md
# Dirty Row Run Coalescer

This block turns per-row dirty flags from an external tracker into a short list of update rectangles for one frame of an 8-bit-per-pixel frame buffer. A frame-start pulse begins a scan over rows 0 to height-1, one row per cycle. For every scanned row the block presents the row index and its byte offset (row times width) so that the tracker can answer with that row's dirty flag in the same cycle.

Consecutive dirty rows are merged into maximal runs. Each run leaves the block as one rectangle on a valid/ready port, given as a start row and a row count. Every rectangle begins at column 0 and spans the whole width. While a rectangle waits for acceptance, the scan holds still. After the last row, any run still open is flushed, and a one-cycle done pulse follows.

A sticky full-refresh flag makes every row count as dirty. Reset, a palette-change pulse and an invalidate pulse set the flag, and the end of each scanned frame clears it.

Top module: `drc_coalescer`

## Requirements
- R1: After reset, rect_valid, done and scan_active are 0, and the first frame scanned makes every row count as dirty. That frame therefore yields the single rectangle (start 0, count height).
- R2: Without stalls, a scan presents rows 0, 1, ..., height-1 in rising order with scan_active high, and scan_addr equals scan_row times width for each row.
- R3: When a clean row (effective flag 0) follows an open run, a rectangle is emitted with the run's first row as rect_y and the clean row's index minus that start as rect_h. A run opens on the first dirty row after a clean row, or at row 0.
- R4: A run that is still open after the last row is emitted with rect_h equal to height minus its start row.
- R5: The full-refresh flag clears when a frame's done pulse is given. The next frame then follows only the row_dirty flags, and a frame with no dirty rows emits no rectangle.
- R6: A one-cycle pulse on palette_wr or on invalidate, given between frames, makes the next frame a single full rectangle (0, height).
- R7: rect_w equals the width input whenever a rectangle is accepted, and every rectangle starts at column 0.
- R8: While rect_valid is 1 and rect_ready is 0, rect_y and rect_h hold their values, rect_valid stays 1, and no row is scanned.
- R9: done is a single-cycle pulse given once per frame, after the last rectangle of that frame has been accepted.
- R10: A frame_start pulse that arrives while a frame is in progress is ignored. The frame's rectangles and its single done pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Pulse that begins a scan when idle |
| height | input | ROW_W | Rows per frame |
| width | input | COL_W | Pixels (bytes) per row |
| row_dirty | input | 1 | Dirty flag for the row on scan_row, same cycle |
| palette_wr | input | 1 | Palette change pulse; sets full refresh |
| invalidate | input | 1 | Invalidate pulse; sets full refresh |
| scan_active | output | 1 | A row is being scanned this cycle |
| scan_row | output | ROW_W | Index of the scanned row |
| scan_addr | output | ROW_W+COL_W | Byte offset of the scanned row |
| rect_valid | output | 1 | Rectangle available |
| rect_ready | input | 1 | Consumer accepts the rectangle |
| rect_y | output | ROW_W | First row of the rectangle |
| rect_h | output | ROW_W | Number of rows in the rectangle |
| rect_w | output | COL_W | Rectangle width (full row) |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with ROW_W = 5 and COL_W = 6. This allows frames of up to 31 rows, so a frame where every row is dirty reaches the largest row index, the largest count and the last row's flush within a few dozen cycles. Widths of up to 63 let the bench check the address product at large row numbers and compare it with an independent product. The frames cover runs that touch row 0 and the last row, a single-row frame, and randomised back-pressure on the rectangle port.

// File: rtl/drc_pkg.sv
package drc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_EMIT = 2'd2,
    ST_DONE = 2'd3
  } scan_state_e;
endpackage

// File: rtl/drc_rst_sync.sv
module drc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/drc_full_flag.sv
module drc_full_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic full_q
);
  logic full_d;

  // a set request wins over the end-of-frame clear
  always_comb begin
    full_d = full_q;
    if (clr_req) full_d = 1'b0;
    if (set_req) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b1;
    else        full_q <= full_d;
  end
endmodule

// File: rtl/drc_row_addr.sv
module drc_row_addr #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [COL_W-1:0]  width,
  output logic [ROW_W-1:0]  row_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic [ROW_W-1:0]  row_d;
  logic [ADDR_W-1:0] addr_d;
  logic              row_en;

  // the byte offset accumulates one row width per step, so no multiplier
  always_comb begin
    row_en = clear | step;
    row_d  = row_q + ROW_W'(1);
    addr_d = addr_q + ADDR_W'(width);
    if (clear) begin
      row_d  = '0;
      addr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      addr_q <= '0;
    end else if (row_en) begin
      row_q  <= row_d;
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/drc_scan_ctrl.sv
module drc_scan_ctrl
  import drc_pkg::*;
#(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [ROW_W-1:0] height,
  input  logic [ROW_W-1:0] row,
  input  logic             dirty_eff,
  input  logic             rect_ready,
  output logic             row_clear,
  output logic             row_step,
  output logic             scan_active,
  output logic             rect_valid,
  output logic [ROW_W-1:0] rect_y,
  output logic [ROW_W-1:0] rect_h,
  output logic             done
);
  scan_state_e      state_q, state_d;
  logic             open_q, open_d;
  logic             last_q, last_d;
  logic [ROW_W-1:0] start_q, start_d;
  logic [ROW_W-1:0] ry_q, ry_d;
  logic [ROW_W-1:0] rh_q, rh_d;
  logic             is_last;
  logic [ROW_W-1:0] run_first;

  assign is_last   = (row == height - ROW_W'(1));
  assign run_first = open_q ? start_q : row;

  always_comb begin
    state_d   = state_q;
    open_d    = open_q;
    last_d    = last_q;
    start_d   = start_q;
    ry_d      = ry_q;
    rh_d      = rh_q;
    row_clear = 1'b0;
    row_step  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (frame_start) begin
          row_clear = 1'b1;
          open_d    = 1'b0;
          last_d    = 1'b0;
          state_d   = (height == '0) ? ST_DONE : ST_SCAN;
        end
      end
      ST_SCAN: begin
        row_step = !is_last;
        if (dirty_eff) begin
          if (!open_q) begin
            start_d = row;
            open_d  = 1'b1;
          end
          if (is_last) begin
            ry_d    = run_first;
            rh_d    = height - run_first;
            open_d  = 1'b0;
            last_d  = 1'b1;
            state_d = ST_EMIT;
          end
        end else if (open_q) begin
          ry_d    = start_q;
          rh_d    = row - start_q;
          open_d  = 1'b0;
          last_d  = is_last;
          state_d = ST_EMIT;
        end else if (is_last) begin
          state_d = ST_DONE;
        end
      end
      ST_EMIT: begin
        if (rect_ready) state_d = last_q ? ST_DONE : ST_SCAN;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      open_q  <= 1'b0;
      last_q  <= 1'b0;
      start_q <= '0;
      ry_q    <= '0;
      rh_q    <= '0;
    end else begin
      state_q <= state_d;
      open_q  <= open_d;
      last_q  <= last_d;
      start_q <= start_d;
      ry_q    <= ry_d;
      rh_q    <= rh_d;
    end
  end

  assign scan_active = (state_q == ST_SCAN);
  assign rect_valid  = (state_q == ST_EMIT);
  assign done        = (state_q == ST_DONE);
  assign rect_y      = ry_q;
  assign rect_h      = rh_q;
endmodule

// File: rtl/drc_coalescer.sv
module drc_coalescer #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [ROW_W-1:0]  height,
  input  logic [COL_W-1:0]  width,
  input  logic              row_dirty,
  input  logic              palette_wr,
  input  logic              invalidate,
  output logic              scan_active,
  output logic [ROW_W-1:0]  scan_row,
  output logic [ADDR_W-1:0] scan_addr,
  output logic              rect_valid,
  input  logic              rect_ready,
  output logic [ROW_W-1:0]  rect_y,
  output logic [ROW_W-1:0]  rect_h,
  output logic [COL_W-1:0]  rect_w,
  output logic              done
);
  logic rst_n_s;
  logic full_q;
  logic row_clear, row_step;

  drc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  drc_full_flag u_full (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .set_req (palette_wr | invalidate),
    .clr_req (done),
    .full_q  (full_q)
  );

  drc_row_addr #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clear  (row_clear),
    .step   (row_step),
    .width  (width),
    .row_q  (scan_row),
    .addr_q (scan_addr)
  );

  drc_scan_ctrl #(.ROW_W(ROW_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .frame_start (frame_start),
    .height      (height),
    .row         (scan_row),
    .dirty_eff   (row_dirty | full_q),
    .rect_ready  (rect_ready),
    .row_clear   (row_clear),
    .row_step    (row_step),
    .scan_active (scan_active),
    .rect_valid  (rect_valid),
    .rect_y      (rect_y),
    .rect_h      (rect_h),
    .done        (done)
  );

  assign rect_w = width;
endmodule

// File: rtl/drc_checks.sv
module drc_checks #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ROW_W-1:0]  height,
  input logic [COL_W-1:0]  width,
  input logic              scan_active,
  input logic [ROW_W-1:0]  scan_row,
  input logic [ADDR_W-1:0] scan_addr,
  input logic              rect_valid,
  input logic              rect_ready,
  input logic [ROW_W-1:0]  rect_y,
  input logic [ROW_W-1:0]  rect_h,
  input logic              done
);
  assert_payload_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rect_valid && !rect_ready |=> rect_valid && $stable(rect_y) && $stable(rect_h));

  assert_no_scan_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_active && rect_valid));

  assert_rect_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rect_valid |-> (rect_h != '0) &&
                   ((ROW_W+1)'(rect_y) + (ROW_W+1)'(rect_h) <= (ROW_W+1)'(height)));

  assert_row_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_active |-> scan_addr == ADDR_W'(scan_row) * ADDR_W'(width));

  assert_row_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_active && $past(scan_active) |-> scan_row == $past(scan_row) + ROW_W'(1));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind drc_coalescer drc_checks #(.ROW_W(ROW_W), .COL_W(COL_W)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .height      (height),
  .width       (width),
  .scan_active (scan_active),
  .scan_row    (scan_row),
  .scan_addr   (scan_addr),
  .rect_valid  (rect_valid),
  .rect_ready  (rect_ready),
  .rect_y      (rect_y),
  .rect_h      (rect_h),
  .done        (done)
);

// File: tb/drc_coalescer_test.sv
`timescale 1ns/1ps
module drc_coalescer_test;
  localparam int ROW_W  = 5;
  localparam int COL_W  = 6;
  localparam int ADDR_W = ROW_W + COL_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              frame_start, palette_wr, invalidate, rect_ready;
  logic [ROW_W-1:0]  height;
  logic [COL_W-1:0]  width;
  logic              row_dirty;
  logic              scan_active, rect_valid, done;
  logic [ROW_W-1:0]  scan_row, rect_y, rect_h;
  logic [ADDR_W-1:0] scan_addr;
  logic [COL_W-1:0]  rect_w;

  logic [31:0] pat;
  logic        exp_full;
  logic        stall_mode;
  logic [7:0]  lfsr;

  int tests_run = 0;
  int tests_failed = 0;

  int got_n, exp_n, done_cnt, exp_row, scan_err, stall_err, w_err;
  int got_y [0:31];
  int got_h [0:31];
  int exp_y [0:31];
  int exp_h [0:31];
  logic prev_stall;
  int   prev_y, prev_h;

  drc_coalescer #(.ROW_W(ROW_W), .COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .height(height),
    .width(width), .row_dirty(row_dirty), .palette_wr(palette_wr),
    .invalidate(invalidate), .scan_active(scan_active), .scan_row(scan_row),
    .scan_addr(scan_addr), .rect_valid(rect_valid), .rect_ready(rect_ready),
    .rect_y(rect_y), .rect_h(rect_h), .rect_w(rect_w), .done(done)
  );

  always #2 clk = ~clk;

  assign row_dirty = pat[scan_row];

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rect_ready = stall_mode ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && (!rect_valid || int'(rect_y) != prev_y || int'(rect_h) != prev_h))
        stall_err++;
      if (prev_stall && scan_active) stall_err++;
      prev_stall = rect_valid && !rect_ready;
      prev_y = int'(rect_y);
      prev_h = int'(rect_h);
      if (rect_valid && rect_ready) begin
        if (got_n < 32) begin
          got_y[got_n] = int'(rect_y);
          got_h[got_n] = int'(rect_h);
        end
        got_n++;
        if (rect_w != width) w_err++;
      end
      if (scan_active) begin
        if (int'(scan_row) != exp_row || int'(scan_addr) != exp_row * int'(width)) scan_err++;
        exp_row++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic check(input bit ok, input string msg);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic build_expect();
    bit open = 0;
    int st = 0;
    exp_n = 0;
    for (int y = 0; y < int'(height); y++) begin
      bit d = pat[y] | exp_full;
      if (d && !open) begin st = y; open = 1; end
      if (!d && open) begin exp_y[exp_n] = st; exp_h[exp_n] = y - st; exp_n++; open = 0; end
    end
    if (open) begin exp_y[exp_n] = st; exp_h[exp_n] = int'(height) - st; exp_n++; end
  endtask

  task automatic run_frame(input string tag, input bit extra_start);
    int guard = 0;
    build_expect();
    got_n = 0; done_cnt = 0; exp_row = 0; scan_err = 0; stall_err = 0; w_err = 0;
    @(posedge clk); #1 frame_start = 1'b1;
    @(posedge clk); #1 frame_start = 1'b0;
    if (extra_start) begin
      repeat (4) @(posedge clk);
      #1 frame_start = 1'b1;
      @(posedge clk); #1 frame_start = 1'b0;
    end
    while (done_cnt == 0 && guard < 3000) begin @(negedge clk); guard++; end
    repeat (6) @(negedge clk);
    exp_full = 1'b0;
    check(got_n == exp_n, $sformatf("%s rect count got %0d expected %0d", tag, got_n, exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++)
      check(got_y[i] == exp_y[i] && got_h[i] == exp_h[i],
            $sformatf("%s rect %0d got (%0d,%0d) expected (%0d,%0d)", tag, i,
                      got_y[i], got_h[i], exp_y[i], exp_h[i]));
    check(done_cnt == 1, $sformatf("%s R9 done pulses got %0d expected 1", tag, done_cnt));
    check(scan_err == 0 && exp_row == int'(height),
          $sformatf("%s R2 scan errors %0d rows %0d expected 0 and %0d", tag, scan_err, exp_row, height));
    check(stall_err == 0, $sformatf("%s R8 stall violations got %0d expected 0", tag, stall_err));
    check(w_err == 0, $sformatf("%s R7 width mismatches got %0d expected 0", tag, w_err));
  endtask

  task automatic t_reset_state();
    check(!rect_valid && !done && !scan_active,
          $sformatf("R1 idle outputs got v=%0b d=%0b s=%0b expected 0 0 0", rect_valid, done, scan_active));
    height = 5'd12; width = 6'd40; pat = 32'h0;
    run_frame("R1 first frame full", 0);
  endtask

  task automatic t_clean_frame();
    pat = 32'h0;
    run_frame("R5 clean after clear", 0);
  endtask

  task automatic t_runs();
    height = 5'd12; width = 6'd17;
    pat = 32'b0110_0010_0111;
    run_frame("R3 mixed runs", 0);
    pat = 32'b0101_0101_0100;
    run_frame("R3 single rows", 0);
  endtask

  task automatic t_flush();
    height = 5'd8; pat = 32'b1100_0000;
    run_frame("R4 tail run", 0);
    pat = 32'b1000_0001;
    run_frame("R4 last row only", 0);
    height = 5'd1; pat = 32'h1;
    run_frame("R4 one row frame", 0);
  endtask

  task automatic t_full_sources();
    height = 5'd10; pat = 32'b00_0100_0000;
    @(posedge clk); #1 palette_wr = 1'b1;
    @(posedge clk); #1 palette_wr = 1'b0;
    exp_full = 1'b1;
    run_frame("R6 palette", 0);
    run_frame("R5 after palette", 0);
    @(posedge clk); #1 invalidate = 1'b1;
    @(posedge clk); #1 invalidate = 1'b0;
    exp_full = 1'b1;
    run_frame("R6 invalidate", 0);
  endtask

  task automatic t_stall();
    height = 5'd31; width = 6'd63;
    pat = 32'h5AC3_3781;
    stall_mode = 1'b1;
    run_frame("R8 backpressure", 0);
    pat = 32'h7FFF_FFFF;
    run_frame("R8 all dirty max", 0);
    stall_mode = 1'b0;
  endtask

  task automatic t_restart_ignored();
    height = 5'd20; width = 6'd9;
    pat = 32'h000F_0F03;
    run_frame("R10 extra start", 1);
  endtask

  initial begin
    #200000;
    tests_run++; tests_failed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; palette_wr = 1'b0; invalidate = 1'b0;
    rect_ready = 1'b1; stall_mode = 1'b0; lfsr = 8'h5D; pat = 32'h0;
    height = 5'd12; width = 6'd40; exp_full = 1'b1; prev_stall = 1'b0;
    got_n = 0; done_cnt = 0; exp_row = 0; scan_err = 0; stall_err = 0; w_err = 0;
    prev_y = 0; prev_h = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_clean_frame();
    t_runs();
    t_flush();
    t_full_sources();
    t_stall();
    t_restart_ignored();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule